// File: doc/BRIEF.md
# Serial EEPROM Slave with Write Guarding

This block is the serial-peripheral slave side of a 1024-byte non-volatile memory. The memory is modelled as a register array that comes out of reset erased, with every byte at FFh. A host selects the block with an active-low chip select. It clocks in an opcode, then a 16-bit address where needed, then data, always most significant bit first. The block answers with read data or its status byte on a serial output. That output is driven only while the block is selected.

Three independent guards must all agree before a byte reaches the array or the status register. The first is a write-enable latch set and cleared by its own opcodes. The second is an active-low protect pin. The third is a 3-bit lock code that marks a region whose bytes are silently dropped. An accepted write starts a busy interval when chip select returns high. The busy interval lasts a parameterised number of clock cycles. During it only the status read is honoured, and at its end the write-enable latch clears itself.

All serial pins are assumed to be already synchronous to `clk`, and each serial clock phase lasts several `clk` cycles. The block detects serial clock and chip-select edges by comparing each input with its value one `clk` earlier.

Top module: `spi_nvm_slave`

## Requirements
- R1: `so_oe` is 0 whenever `cs_n` is 1. It is 1 while the block is selected and armed.
- R2: After reset the block ignores every command, and keeps `so_oe` low, until it has seen `cs_n` go from 1 to 0.
- R3: Both idle-low (mode 0) and idle-high (mode 3) serial clocks work. SI is taken on the rising `sck` edge and SO moves on the falling `sck` edge, most significant bit first.
- R4: Opcode 06h sets the write-enable latch and opcode 04h clears it. The latch reads back as status bit 1.
- R5: Opcode 03h with a 16-bit address reads bytes starting at the address formed by the low 10 address bits. The address increments after each byte and wraps from 3FFh to 000h.
- R6: Opcode 02h with a 16-bit address stores the data bytes that follow, up to 16 per command. When the address passes the end of a 16-byte page, it wraps to the start of the same page.
- R7: A memory or status write is ignored when the write-enable latch is clear.
- R8: While `wp_n` is 0, neither memory writes nor status writes change anything.
- R9: Status bits [4:2] form the lock code, and data bytes aimed at a locked address are dropped. Code 0 locks nothing. Code 1 locks 000h–00Fh and code 2 locks 3F0h–3FFh. Codes 3 to 6 lock quarter (code−3), that is 100h×(code−3) to 100h×(code−3)+FFh. Code 7 locks 000h–1FFh.
- R10: Opcode 05h returns {000b, lock[2:0], latch, busy} and repeats it for every further byte.
- R11: Opcode 01h takes one data byte. Its bits [4:2] become the lock code and its other bits are ignored.
- R12: After at least one byte or the status byte has been accepted, the rising edge of `cs_n` starts busy (status bit 0) for T_WRITE cycles. The latch clears when busy ends. A command that stored nothing starts no busy interval.
- R13: While busy, every opcode other than 05h is ignored, including 04h and 06h.
- R14: After reset the status reads 00h and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all serial pins |
| rst_n | input | 1 | Active-low reset (power-up) |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad, high-impedance when 0 |

## Verification
The properties assume that `sck` and `cs_n` do not change in the same `clk` cycle. They also assume that each `sck` level lasts long enough for the shifted output to settle before the next rising edge. The bench meets both by holding every serial clock phase for four `clk` cycles and by changing chip select only half a serial period away from any clock edge. Busy and write checks assume that a new write is begun only after the busy interval has run out, except where the bench deliberately drives commands into a busy interval to show that they are ignored.

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
  parameter int ADDR_W  = 10,
  parameter int PAGE_W  = 4,
  parameter int T_WRITE = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(T_WRITE + 1);
  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_READ = 8'h03,
                         OP_WRDI = 8'h04, OP_RDSR  = 8'h05, OP_WREN = 8'h06;

  logic              sck_q, cs_q, armed, go, wel, wr_any;
  logic [2:0]        bitcnt, lock;
  logic [1:0]        nbyte;
  logic [6:0]        sh;
  logic [7:0]        op, pend, osh;
  logic [ADDR_W-9:0] ahi;
  logic [ADDR_W-1:0] addr;
  logic [BW-1:0]     bcnt;
  logic [7:0]        mem [DEPTH];

  function automatic logic locked(input logic [2:0] code, input logic [ADDR_W-1:0] a);
    case (code)
      3'd1:    return a[ADDR_W-1:PAGE_W] == '0;
      3'd2:    return a[ADDR_W-1:PAGE_W] == '1;
      3'd3:    return a[ADDR_W-1:ADDR_W-2] == 2'd0;
      3'd4:    return a[ADDR_W-1:ADDR_W-2] == 2'd1;
      3'd5:    return a[ADDR_W-1:ADDR_W-2] == 2'd2;
      3'd6:    return a[ADDR_W-1:ADDR_W-2] == 2'd3;
      3'd7:    return ~a[ADDR_W-1];
      default: return 1'b0;
    endcase
  endfunction

  logic              busy, sck_r, sck_f, cs_rise, cs_fall, byte_done, we;
  logic [7:0]        rx, stat;
  logic [ADDR_W-1:0] a_new;
  logic [PAGE_W-1:0] pg_nxt;

  assign busy      = bcnt != '0;
  assign sck_r     = sck & ~sck_q & ~cs_n & armed;
  assign sck_f     = ~sck & sck_q & ~cs_n & armed;
  assign cs_rise   = cs_n & ~cs_q;
  assign cs_fall   = ~cs_n & cs_q;
  assign byte_done = sck_r && bitcnt == 3'd7;
  assign rx        = {sh, si};
  assign stat      = {3'b000, lock, wel, busy};
  assign a_new     = {ahi, rx};
  assign pg_nxt    = addr[PAGE_W-1:0] + PAGE_W'(1);
  assign we        = byte_done && go && op == OP_WRITE && nbyte == 2'd3 &&
                     wel && wp_n && !locked(lock, addr);
  assign so        = osh[7];
  assign so_oe     = ~cs_n & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[addr] <= rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b0; armed <= 1'b0; go <= 1'b0;
      wel <= 1'b0; wr_any <= 1'b0; bitcnt <= '0; lock <= '0;
      nbyte <= '0; sh <= '0; op <= '0; pend <= '0; osh <= '0;
      ahi <= '0; addr <= '0; bcnt <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_fall) armed <= 1'b1;
      if (busy) begin
        bcnt <= bcnt - 1'b1;
        if (bcnt == BW'(1)) wel <= 1'b0;
      end
      if (cs_n) begin
        bitcnt <= '0;
        nbyte  <= '0;
        go     <= 1'b0;
      end
      if (cs_rise) begin
        wr_any <= 1'b0;
        if (wr_any) bcnt <= BW'(T_WRITE);
      end
      if (sck_r) begin
        sh     <= rx[6:0];
        bitcnt <= bitcnt + 1'b1;
      end
      if (byte_done) begin
        if (nbyte != 2'd3) nbyte <= nbyte + 1'b1;
        if (nbyte == 2'd0) begin
          op <= rx;
          go <= !busy || rx == OP_RDSR;
          if (!busy && rx == OP_WREN) wel <= 1'b1;
          if (!busy && rx == OP_WRDI) wel <= 1'b0;
          pend <= stat;
        end else if (go) begin
          if (op == OP_RDSR) pend <= stat;
          if (nbyte == 2'd1) begin
            ahi <= rx[ADDR_W-9:0];
            if (op == OP_WRSR && wel && wp_n) begin
              lock   <= rx[4:2];
              wr_any <= 1'b1;
            end
          end else if (nbyte == 2'd2) begin
            if (op == OP_READ) begin
              pend <= mem[a_new];
              addr <= a_new + 1'b1;
            end else begin
              addr <= a_new;
            end
          end else begin
            if (op == OP_READ) begin
              pend <= mem[addr];
              addr <= addr + 1'b1;
            end
            if (op == OP_WRITE) begin
              addr <= {addr[ADDR_W-1:PAGE_W], pg_nxt};
              if (we) wr_any <= 1'b1;
            end
          end
        end
      end
      if (sck_f) osh <= (bitcnt == 3'd0) ? pend : {osh[6:0], 1'b0};
    end
  end
endmodule

module spi_nvm_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_n,
  input logic       so_oe,
  input logic       armed,
  input logic       busy,
  input logic       wel,
  input logic       we,
  input logic [2:0] lock
);
  p_quiet_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_oe);
  p_quiet_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !so_oe);
  p_no_write_unlatched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> wel);
  p_no_write_protected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> wp_n);
  p_busy_after_deselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cs_n);
  p_latch_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  p_no_write_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !busy);
  p_lock_held_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lock));
endmodule

bind spi_nvm_slave spi_nvm_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .so_oe(so_oe),
  .armed(armed), .busy(busy), .wel(wel), .we(we), .lock(lock)
);

// File: tb/spi_nvm_slave_tb.sv
module spi_nvm_slave_tb;
  localparam int TW = 600;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sck, cs_n, si, wp_n, so, so_oe;
  spi_nvm_slave #(.T_WRITE(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .wp_n(wp_n), .so(so), .so_oe(so_oe));

  int nvec = 0, nbad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  string      tag_q[$];
  logic       mode3 = 1'b0;
  logic [7:0] ref_mem [1024];
  logic       ref_wel = 1'b0;
  logic [2:0] ref_lock = 3'd0;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  initial forever begin
    wait (rx_q.size() > 0);
    begin
      logic [7:0] g, e;
      string t;
      g = rx_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(g === e, t, g, e);
    end
  end

  function automatic bit lk(input int c, input int a);
    case (c)
      1: return a < 16;
      2: return a >= 1008;
      3, 4, 5, 6: return (a >> 8) == c - 3;
      7: return a < 512;
      default: return 0;
    endcase
  endfunction

  task automatic half(); repeat (4) @(negedge clk); endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      if (mode3) sck = 1'b0;
      si = tx[i];
      half();
      r[i] = so;
      sck = 1'b1;
      half();
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic begin_cmd(); sck = mode3; half(); cs_n = 1'b0; half(); endtask
  task automatic end_cmd(); half(); cs_n = 1'b1; sck = mode3; half(); half(); endtask
  task automatic settle(); repeat (TW + 20) @(negedge clk); ref_wel = 1'b0; endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    begin_cmd(); xbyte(op, d); end_cmd();
  endtask
  task automatic wren(); cmd1(8'h06); ref_wel = 1'b1; endtask
  task automatic wrdi(); cmd1(8'h04); ref_wel = 1'b0; endtask

  task automatic rdsr(input bit bsy, input string tag);
    logic [7:0] d, e;
    e = {3'b000, ref_lock, ref_wel, bsy};
    begin_cmd(); xbyte(8'h05, d);
    for (int k = 0; k < 2; k++) begin
      exp_q.push_back(e); tag_q.push_back(tag);
      xbyte(8'h00, d); rx_q.push_back(d);
    end
    end_cmd();
  endtask

  task automatic rd(input logic [15:0] a, input int n, input string tag);
    logic [7:0] d;
    begin_cmd(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(ref_mem[(int'(a) + k) % 1024]); tag_q.push_back(tag);
      xbyte(8'h00, d); rx_q.push_back(d);
    end
    end_cmd();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                    input logic [7:0] d2, input logic [7:0] d3, input int n, input bit wait_done);
    logic [7:0] d;
    logic [7:0] v [4];
    bit any;
    v[0] = d0; v[1] = d1; v[2] = d2; v[3] = d3; any = 0;
    begin_cmd(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      int ad;
      ad = (int'(a[9:0]) & ~15) | ((int'(a[3:0]) + k) & 15);
      xbyte(v[k], d);
      if (ref_wel && wp_n && !lk(ref_lock, ad)) begin ref_mem[ad] = v[k]; any = 1; end
    end
    end_cmd();
    if (any && wait_done) settle();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    bit any;
    any = ref_wel && wp_n;
    begin_cmd(); xbyte(8'h01, d); xbyte(v, d); end_cmd();
    if (any) begin ref_lock = v[4:2]; settle(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int probes [7] = '{'h005, 'h3F5, 'h0F0, 'h150, 'h250, 'h350, 'h1F8};
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; wp_n = 1'b1;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(so_oe == 1'b0, "R2 so_oe before arming", {7'd0, so_oe}, 8'h00);
    xbyte(8'h06, d);
    chk(so_oe == 1'b0, "R2 so_oe during unarmed select", {7'd0, so_oe}, 8'h00);
    cs_n = 1'b1; half(); half();
    chk(so_oe == 1'b0, "R1 so_oe deselected", {7'd0, so_oe}, 8'h00);
    rdsr(0, "R2 unarmed opcode ignored / R14 status reset");
    begin_cmd();
    chk(so_oe == 1'b1, "R1 so_oe selected", {7'd0, so_oe}, 8'h01);
    end_cmd();
    rd(16'h0000, 3, "R14 erased array");

    wr(16'h0010, 8'h5A, 0, 0, 0, 1, 1);
    rdsr(0, "R7/R12 unlatched write starts no busy");
    rd(16'h0010, 1, "R7 unlatched write ignored");

    wren(); rdsr(0, "R4 latch set");
    wrdi(); rdsr(0, "R4 latch cleared");
    wren();
    wr(16'h001E, 8'h11, 8'h22, 8'h33, 8'h44, 4, 0);
    rdsr(1, "R12 busy after write");
    cmd1(8'h04);
    rdsr(1, "R13 latch clear ignored while busy");
    begin_cmd(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h20, d); xbyte(8'h99, d); end_cmd();
    settle();
    rdsr(0, "R12 busy ended and latch cleared");
    rd(16'h001E, 2, "R6 page write head");
    rd(16'h0010, 2, "R6 page wrap");
    rd(16'h0020, 1, "R13 write ignored while busy");

    mode3 = 1'b1;
    wren(); wr(16'h03FF, 8'hA5, 0, 0, 0, 1, 1);
    rd(16'h03FF, 2, "R3 mode 3 / R5 array wrap");
    rd(16'hFC10, 1, "R5 upper address bits ignored");
    mode3 = 1'b0;
    rd(16'h03FE, 3, "R3 mode 0 / R5 wrap");

    wp_n = 1'b0;
    wren(); wr(16'h0100, 8'h77, 0, 0, 0, 1, 1);
    rd(16'h0100, 1, "R8 protect pin blocks memory write");
    wrsr(8'h1C);
    rdsr(0, "R8 protect pin blocks status write");
    wp_n = 1'b1;

    for (int c = 1; c < 8; c++) begin
      wren(); wrsr(8'(c << 2));
      rdsr(0, "R10/R11 lock code readback");
      for (int k = 0; k < 7; k++) begin
        wren(); wr(16'(probes[k]), 8'(c * 16 + k), 0, 0, 0, 1, 1);
        if (ref_wel) wrdi();
      end
      for (int k = 0; k < 7; k++) rd(16'(probes[k]), 1, "R9 locked region");
    end
    wren(); wrsr(8'hFF);
    rdsr(0, "R11 other status bits ignored");
    wren(); wrsr(8'h00);
    rdsr(0, "R11 lock cleared");

    wait (rx_q.size() == 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule